// File: doc/BRIEF.md
# Serial EEPROM Code Boot Loader

After reset this block fills an on-chip code RAM with program bytes. In serial boot mode it acts as the only master on a dedicated two-wire bus. It addresses a serial EEPROM, sets the EEPROM's internal word pointer to zero, and then streams a fixed number of bytes back. Each byte is written to the RAM at the next ascending address. In host mode the bus stays silent: bytes that a host places on a code-input port are written to the same RAM in the same ascending order.

Either way, the block raises a done flag once the parameterised byte count is in the RAM. If the EEPROM fails to acknowledge a byte, the transfer stops and a sticky error flag is raised. The bus lines are open-drain: the block only produces pull-low enables and never drives a line high.

The bus speed, the two low address bits of the EEPROM and the boot mode come from pins. They are captured once, when loading starts after reset. The SCL timing is derived from a system-clock parameter, so each speed code gives its nominal rate.

Top module: `i2c_code_boot`

## Requirements
- R1: The EEPROM address byte is sent MSB first as 1,0,1,0,0, then `dev_sel[1]`, then `dev_sel[0]`, then the direction bit (0 = write, 1 = read).
- R2: With `spd_code` = 0, 1, 2 or 3, SCL runs at 800, 400, 200 or 100 kHz respectively. Each SCL high pulse of a data or acknowledge bit lasts exactly CLK_HZ/(2*rate) clock cycles.
- R3: In serial mode the bus sequence is: START, address+write, word-address high byte 0x00, word-address low byte 0x00, repeated START, address+read, and then sequential reads of NBYTES bytes.
- R4: The block acknowledges (pulls SDA low) after every read byte except the last one. It leaves the last one unacknowledged and then issues exactly one STOP.
- R5: Each received byte is written to the RAM with one single-cycle `ram_we` pulse. Addresses run 0, 1, 2, ... in order, and the data equals the EEPROM byte at the same offset.
- R6: `load_done` rises after exactly NBYTES RAM writes. It stays high until reset, and no RAM write follows it.
- R7: If the EEPROM fails to acknowledge any byte the block sends (SDA high in the acknowledge slot), the block issues a STOP and raises a sticky `load_err`. It makes no RAM write and never raises `load_done`.
- R8: With `host_mode` = 1 the block produces no SCL or SDA activity at all. Each `host_we` cycle writes `host_data` to the next RAM address from 0 upward. `load_done` rises with the NBYTES-th write, and later `host_we` pulses are ignored.
- R9: `scl_oe` and `sda_oe` are pull-low enables (1 = pull line low). Both are 0 during reset and after the load has finished or failed.
- R10: `host_mode`, `spd_code` and `dev_sel` are sampled in the first cycle after reset. Changing them during a load has no effect on its speed, its address bytes or its outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | 0 = boot from the serial EEPROM, 1 = load from host writes |
| spd_code | input | 2 | SCL rate select (0: 800 kHz ... 3: 100 kHz) |
| dev_sel | input | 2 | Two low bits of the EEPROM device address |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| host_we | input | 1 | Host code-input write strobe |
| host_data | input | 8 | Host code-input byte |
| ram_we | output | 1 | Code RAM write enable |
| ram_addr | output | $clog2(NBYTES) | Code RAM write address |
| ram_wdata | output | 8 | Code RAM write data |
| load_done | output | 1 | All NBYTES bytes are in the RAM |
| load_err | output | 1 | The EEPROM failed to acknowledge |

## Verification
The bench places a behavioural EEPROM on the bus and probes it in several ways:
- It refuses the address byte, the low word-address byte, or the read-address byte. A design that ignored the acknowledge would write garbage into the RAM or report done.
- It changes the speed and address pins in the middle of a load. A design that failed to latch them would stretch SCL or send a wrong read address, which the model refuses.
- It counts master acknowledges on reads. A design that acknowledged the final byte would hold the EEPROM on the bus past the STOP.
- In host mode it checks for total bus silence, and it sends an extra write after completion, which a design lacking the count limit would store over address zero.

// File: rtl/i2c_code_boot.sv
module i2c_code_boot #(
  parameter int CLK_HZ = 50_000_000,
  parameter int NBYTES = 256
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_mode,
  input  logic [1:0]                  spd_code,
  input  logic [1:0]                  dev_sel,
  input  logic                        sda_in,
  output logic                        scl_oe,
  output logic                        sda_oe,
  input  logic                        host_we,
  input  logic [7:0]                  host_data,
  output logic                        ram_we,
  output logic [$clog2(NBYTES)-1:0]   ram_addr,
  output logic [7:0]                  ram_wdata,
  output logic                        load_done,
  output logic                        load_err
);
  localparam int AW = $clog2(NBYTES);
  localparam int CW = $clog2(NBYTES + 1);
  localparam int Q0 = CLK_HZ / 3_200_000;
  localparam int QW = $clog2(Q0 * 8 + 1);
  localparam logic [4:0] DEV_HI = 5'b10100;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_RSTART, S_BIT, S_STOP, S_HOST, S_DONE, S_ERR
  } st_t;

  st_t            st;
  logic [1:0]     ph;
  logic [QW-1:0]  qcnt;
  logic [1:0]     spd_q, sel_q;
  logic [3:0]     bitn;
  logic [7:0]     sh;
  logic           rd, fail;
  logic [1:0]     stage;
  logic [CW-1:0]  cnt;
  logic           scl_lo, sda_lo, bitv, sda_d1;

  wire [QW-1:0] qlen = QW'(Q0) << spd_q;
  wire          tick = (qcnt == '0);
  wire          last = (cnt == CW'(NBYTES - 1));

  assign load_done = (st == S_DONE);
  assign load_err  = (st == S_ERR);

  always_comb begin
    if (bitn[3]) bitv = rd ? last : 1'b1;
    else         bitv = rd ? 1'b1 : sh[7];
    scl_lo = 1'b0;
    sda_lo = 1'b0;
    unique case (st)
      S_START:  begin scl_lo = 1'b0;        sda_lo = ph[1];        end
      S_RSTART: begin scl_lo = (ph == 2'd0); sda_lo = ph[1];       end
      S_BIT:    begin scl_lo = ~ph[1];      sda_lo = ~bitv;        end
      S_STOP:   begin scl_lo = ~ph[1];      sda_lo = (ph != 2'd3); end
      default:  begin scl_lo = 1'b0;        sda_lo = 1'b0;         end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_oe <= 1'b0;
      sda_d1 <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      scl_oe <= scl_lo;
      sda_d1 <= sda_lo;
      sda_oe <= sda_d1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qcnt <= '0;
    else if (st == S_IDLE) qcnt <= (QW'(Q0) << spd_code) - 1'b1;
    else if (tick) qcnt <= qlen - 1'b1;
    else qcnt <= qcnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; spd_q <= '0; sel_q <= '0; bitn <= '0;
      sh <= '0; rd <= 1'b0; fail <= 1'b0; stage <= '0; cnt <= '0;
      ram_we <= 1'b0; ram_addr <= '0; ram_wdata <= '0;
    end else begin
      ram_we <= 1'b0;
      unique case (st)
        S_IDLE: begin
          spd_q <= spd_code;
          sel_q <= dev_sel;
          ph    <= '0;
          st    <= host_mode ? S_HOST : S_START;
        end
        S_HOST: if (host_we) begin
          ram_we    <= 1'b1;
          ram_addr  <= cnt[AW-1:0];
          ram_wdata <= host_data;
          cnt       <= cnt + 1'b1;
          if (last) st <= S_DONE;
        end
        S_DONE, S_ERR: ;
        default: if (tick) begin
          ph <= ph + 1'b1;
          if (st == S_BIT && ph == 2'd2) begin
            if (rd && !bitn[3]) sh <= {sh[6:0], sda_in};
            if (!rd && bitn[3]) fail <= sda_in;
          end
          if (ph == 2'd3) begin
            unique case (st)
              S_START: begin
                st <= S_BIT; bitn <= '0; rd <= 1'b0; stage <= 2'd0;
                sh <= {DEV_HI, sel_q, 1'b0};
              end
              S_RSTART: begin
                st <= S_BIT; bitn <= '0; stage <= 2'd3;
                sh <= {DEV_HI, sel_q, 1'b1};
              end
              S_STOP: st <= fail ? S_ERR : S_DONE;
              default: begin
                if (!bitn[3]) begin
                  bitn <= bitn + 1'b1;
                  if (!rd) sh <= {sh[6:0], 1'b0};
                end else begin
                  bitn <= '0;
                  if (rd) begin
                    ram_we    <= 1'b1;
                    ram_addr  <= cnt[AW-1:0];
                    ram_wdata <= sh;
                    cnt       <= cnt + 1'b1;
                    if (last) st <= S_STOP;
                  end else if (fail) begin
                    st <= S_STOP;
                  end else begin
                    unique case (stage)
                      2'd0: begin stage <= 2'd1; sh <= 8'h00; end
                      2'd1: begin stage <= 2'd2; sh <= 8'h00; end
                      2'd2: st <= S_RSTART;
                      default: rd <= 1'b1;
                    endcase
                  end
                end
              end
            endcase
          end
        end
      endcase
    end
  end
endmodule

module i2c_code_boot_chk #(
  parameter int NBYTES = 256
)(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      scl_oe,
  input logic                      sda_oe,
  input logic                      ram_we,
  input logic [$clog2(NBYTES)-1:0] ram_addr,
  input logic                      load_done,
  input logic                      load_err
);
  localparam int AW = $clog2(NBYTES);
  localparam int CW = $clog2(NBYTES + 1);
  logic [CW-1:0] wr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_seen <= '0;
    else if (ram_we) wr_seen <= wr_seen + 1'b1;
  end

  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_addr == wr_seen[AW-1:0]);
  a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> wr_seen < CW'(NBYTES));
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);
  a_r6_no_write_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_done) |-> !ram_we);
  a_r6_done_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_done) |=> wr_seen == CW'(NBYTES));
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |=> load_err && !load_done);
  a_r9_released_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done || load_err) |-> !scl_oe && !sda_oe);
endmodule

bind i2c_code_boot i2c_code_boot_chk #(.NBYTES(NBYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .ram_we(ram_we), .ram_addr(ram_addr),
  .load_done(load_done), .load_err(load_err)
);

// File: tb/i2c_code_boot_tb_top.sv
module i2c_code_boot_tb_top;
  localparam int CLK_HZ = 16_000_000;
  localparam int NB     = 8;
  localparam int AW     = $clog2(NB);
  localparam int NV     = 8;
  // {mode, spd, sel, slave_sel, nack_byte(15=none), late_spd, exp_err}
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 2'd0, 2'd0, 2'd0, 4'd15, 2'd3, 1'b0},
    {1'b0, 2'd1, 2'd2, 2'd2, 4'd15, 2'd0, 1'b0},
    {1'b0, 2'd2, 2'd1, 2'd1, 4'd15, 2'd3, 1'b0},
    {1'b0, 2'd3, 2'd3, 2'd3, 4'd15, 2'd0, 1'b0},
    {1'b0, 2'd0, 2'd1, 2'd2, 4'd15, 2'd1, 1'b1},
    {1'b0, 2'd0, 2'd0, 2'd0, 4'd2,  2'd2, 1'b1},
    {1'b0, 2'd1, 2'd2, 2'd2, 4'd3,  2'd0, 1'b1},
    {1'b1, 2'd0, 2'd0, 2'd0, 4'd15, 2'd3, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_mode = 1'b0, host_we = 1'b0;
  logic [1:0] spd_code = '0, dev_sel = '0;
  logic [7:0] host_data = '0;
  logic scl_oe, sda_oe, ram_we, load_done, load_err;
  logic [AW-1:0] ram_addr;
  logic [7:0] ram_wdata;
  logic slv_lo = 1'b0;
  wire scl = ~scl_oe;
  wire sda = ~(sda_oe | slv_lo);

  always #4 clk = ~clk;

  i2c_code_boot #(.CLK_HZ(CLK_HZ), .NBYTES(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .spd_code(spd_code),
    .dev_sel(dev_sel), .sda_in(sda), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .host_we(host_we), .host_data(host_data), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .load_done(load_done),
    .load_err(load_err));

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(string req, bit ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem(int i);
    return 8'(i * 29 + 7);
  endfunction

  // Behavioural EEPROM
  int pos, hdr_idx, ptr, starts, stops, m_acks, m_nacks, scl_falls, nack_at;
  logic rdmode, go_read, mack;
  logic [7:0] sh, dat;
  logic [1:0] ssel;
  logic [7:0] rx [4];

  always @(negedge sda) if (scl === 1'b1) begin
    starts++; pos = 0; rdmode = 1'b0; go_read = 1'b0; slv_lo = 1'b0;
  end
  always @(posedge sda) if (scl === 1'b1) begin
    stops++; rdmode = 1'b0; slv_lo = 1'b0;
  end
  always @(posedge scl) begin
    if (!rdmode && pos < 8) sh = {sh[6:0], sda};
    if (rdmode && pos == 8) begin
      mack = sda;
      if (sda) m_nacks++; else m_acks++;
    end
    pos++;
  end
  always @(negedge scl) if (rst_n) begin
    scl_falls++;
    if (!rdmode) begin
      if (pos == 8) begin
        bit ok = 1'b1;
        if (hdr_idx < 4) rx[hdr_idx] = sh;
        if (hdr_idx == 0 || hdr_idx == 3) ok = (sh[7:1] == {5'b10100, ssel});
        if (hdr_idx == nack_at) ok = 1'b0;
        go_read = ok && sh[0] && (hdr_idx == 0 || hdr_idx == 3);
        hdr_idx++;
        slv_lo = ok;
      end else if (pos == 9) begin
        pos = 0; slv_lo = 1'b0;
        if (go_read) begin
          rdmode = 1'b1; go_read = 1'b0;
          ptr = {24'd0, rx[1], rx[2]};
          dat = mem(ptr); slv_lo = ~dat[7];
        end
      end
    end else begin
      if (pos >= 1 && pos <= 7) slv_lo = ~dat[7 - pos];
      else if (pos == 8) slv_lo = 1'b0;
      else if (pos == 9) begin
        pos = 0;
        if (mack) slv_lo = 1'b0;
        else begin ptr++; dat = mem(ptr); slv_lo = ~dat[7]; end
      end
    end
  end

  // RAM and SCL monitors
  int nwr, hw, minhw;
  logic [7:0] wa [16];
  logic [7:0] wd [16];
  always @(posedge clk) if (rst_n) begin
    if (ram_we && nwr < 16) begin wa[nwr] = 8'(ram_addr); wd[nwr] = ram_wdata; end
    if (ram_we) nwr++;
    if (scl) hw++;
    else if (hw > 0) begin if (hw < minhw) minhw = hw; hw = 0; end
  end

  task automatic reset_model();
    pos = 0; hdr_idx = 0; ptr = 0; starts = 0; stops = 0; m_acks = 0; m_nacks = 0;
    scl_falls = 0; rdmode = 1'b0; go_read = 1'b0; mack = 1'b0; slv_lo = 1'b0;
    nwr = 0; hw = 0; minhw = 1_000_000;
    for (int k = 0; k < 4; k++) rx[k] = 8'hEE;
  endtask

  task automatic wait_end(int limit);
    for (int k = 0; k < limit && !(load_done || load_err); k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic start_run(bit mode, logic [1:0] spd, logic [1:0] sel,
                           logic [1:0] s_sel, int nk);
    @(negedge clk);
    rst_n = 1'b0;
    host_mode = mode; spd_code = spd; dev_sel = sel; ssel = s_sel; nack_at = nk;
    reset_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_good_eeprom(logic [1:0] spd, logic [1:0] sel);
    int exp_hw = CLK_HZ / (2 * (800_000 >> spd));
    chk("R6 done", load_done === 1'b1, int'(load_done), 1);
    chk("R7 no err", load_err === 1'b0, int'(load_err), 0);
    chk("R1 write address", rx[0] == {5'b10100, sel, 1'b0}, rx[0], {5'b10100, sel, 1'b0});
    chk("R3 word addr hi", rx[1] == 8'h00, rx[1], 0);
    chk("R3 word addr lo", rx[2] == 8'h00, rx[2], 0);
    chk("R1 R10 read address", rx[3] == {5'b10100, sel, 1'b1}, rx[3], {5'b10100, sel, 1'b1});
    chk("R3 start count", starts == 2, starts, 2);
    chk("R4 acks", m_acks == NB - 1, m_acks, NB - 1);
    chk("R4 final nack", m_nacks == 1, m_nacks, 1);
    chk("R4 stop", stops == 1, stops, 1);
    chk("R2 R10 scl high", minhw == exp_hw, minhw, exp_hw);
    chk("R5 write count", nwr == NB, nwr, NB);
    for (int k = 0; k < NB; k++) begin
      chk("R5 addr", wa[k] == 8'(k), wa[k], k);
      chk("R5 data", wd[k] == mem(k), wd[k], mem(k));
    end
    chk("R9 scl released", scl_oe === 1'b0, int'(scl_oe), 0);
    chk("R9 sda released", sda_oe === 1'b0, int'(sda_oe), 0);
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    reset_model();
    repeat (3) @(negedge clk);
    chk("R9 reset scl", scl_oe === 1'b0, int'(scl_oe), 0);
    chk("R9 reset sda", sda_oe === 1'b0, int'(sda_oe), 0);
    chk("R6 reset done", load_done === 1'b0, int'(load_done), 0);
    chk("R7 reset err", load_err === 1'b0, int'(load_err), 0);

    for (int v = 0; v < NV; v++) begin
      logic [13:0] e = VEC[v];
      start_run(e[13], e[12:11], e[10:9], e[8:7], int'(e[6:3]));
      if (e[13]) begin
        repeat (3) @(negedge clk);
        for (int k = 0; k < NB; k++) begin
          host_we = 1'b1; host_data = 8'(8'h5A ^ (k * 17));
          @(negedge clk);
          host_we = 1'b0;
          repeat (k % 3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk("R8 done", load_done === 1'b1, int'(load_done), 1);
        chk("R8 bus silent", scl_falls == 0 && starts == 0, scl_falls + starts, 0);
        chk("R8 count", nwr == NB, nwr, NB);
        for (int k = 0; k < NB; k++) begin
          chk("R8 addr", wa[k] == 8'(k), wa[k], k);
          chk("R8 data", wd[k] == 8'(8'h5A ^ (k * 17)), wd[k], 8'(8'h5A ^ (k * 17)));
        end
        host_we = 1'b1; host_data = 8'hC3;
        @(negedge clk);
        host_we = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 R6 write after done ignored", nwr == NB, nwr, NB);
      end else begin
        repeat (100) @(negedge clk);
        spd_code = e[2:1]; dev_sel = ~e[10:9]; host_mode = 1'b1;
        wait_end(60_000);
        if (!e[0]) check_good_eeprom(e[12:11], e[10:9]);
        else begin
          chk("R7 err", load_err === 1'b1, int'(load_err), 1);
          chk("R7 no done", load_done === 1'b0, int'(load_done), 0);
          chk("R7 no writes", nwr == 0, nwr, 0);
          chk("R7 stop", stops == 1, stops, 1);
          chk("R9 released after err", scl_oe === 1'b0 && sda_oe === 1'b0,
              int'(scl_oe) + int'(sda_oe), 0);
        end
      end
    end

    // directed: reset in the middle of a load, then a clean reload
    start_run(1'b0, 2'd0, 2'd1, 2'd1, 15);
    repeat (900) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 mid-load reset scl", scl_oe === 1'b0, int'(scl_oe), 0);
    chk("R9 mid-load reset sda", sda_oe === 1'b0, int'(sda_oe), 0);
    start_run(1'b0, 2'd0, 2'd1, 2'd1, 15);
    wait_end(60_000);
    check_good_eeprom(2'd0, 2'd1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule